// File: doc/BRIEF.md
# Outbound PCIe Window Request Translator

This block sits on the root-complex side of a PCIe controller, between a single-beat memory-mapped slave port and the outbound request descriptor interface. Every slave access is decoded against three address windows: a 4KB remote configuration window, a 4KB I/O window and a large memory data window. A hit is turned into one configuration, I/O or memory descriptor carrying the translated address and, for configuration requests, the routing identifier. Read data returns on a completion input and is handed back to the slave port.

A small register port holds the I/O base, the target bus/device/function identifier and a bus-master-enable bit, and reports the link status. Requests are held without any error or timeout while bus mastering is off. Configuration and I/O requests are also held while the link is down, so the slave port stays stalled. Bursts, misaligned accesses and misses on all windows are refused at once with an error response. Only one request is in flight at a time.

Top module: `pcie_win_xlate`

## Requirements
- R1: During and after reset, `s_ready` and `d_valid` are low and all three registers read back as zero (with `link_up` low).
- R2: The register port reads back what was written. Index 0 holds the I/O base in bits 31:12 with bits 11:0 reading zero. Index 1 holds the target identifier in bits 15:0 (bus 15:8, device 7:3, function 2:0). Index 2 holds bus-master-enable in bit 0 and shows `link_up` in read-only bit 1.
- R3: An access in the configuration window gives a configuration read (kind 4) or write (kind 5). Its address is the low 12 bits of the access address with bits 31:12 zero, and its routing identifier is the programmed target identifier.
- R4: An access in the I/O window gives an I/O read (kind 2) or write (kind 3). Its address takes bits 31:12 from the I/O base register and bits 11:0 from the access address.
- R5: An access in the memory window gives a memory read (kind 0) or write (kind 1). The access address is passed through unchanged and the routing identifier is zero.
- R6: Every descriptor has byte enables 4'hF and a length of one dword. Write data is carried on `d_data`, and reads carry zero there.
- R7: While bus-master-enable is clear, a pending request is held, `d_valid` stays low and no response is given. `d_valid` rises in the first cycle after the bit is set.
- R8: While `link_up` is low, configuration and I/O requests are held with no response. Memory requests are still issued.
- R9: A burst attempt, a non-dword-aligned address or an address outside all windows gets `s_ready` with `s_err` in the next cycle and produces no descriptor.
- R10: A write completes with `s_ready` one cycle after its descriptor is accepted. A read completes one cycle after `c_valid`, with `s_rdata` equal to `c_data`. `s_ready` lasts exactly one cycle.
- R11: While `d_valid` is high and `d_ready` is low, the descriptor fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Slave access request, held until s_ready |
| s_write | input | 1 | 1 = write, 0 = read |
| s_burst | input | 1 | Access is a burst attempt |
| s_addr | input | 32 | Access byte address |
| s_wdata | input | 32 | Write data |
| s_ready | output | 1 | One-cycle completion pulse |
| s_err | output | 1 | Error flag, valid with s_ready |
| s_rdata | output | 32 | Read data, valid with s_ready |
| r_we | input | 1 | Register write strobe |
| r_idx | input | 2 | Register index |
| r_wdata | input | 32 | Register write data |
| r_rdata | output | 32 | Register read data (combinational) |
| link_up | input | 1 | Link operational status |
| d_valid | output | 1 | Descriptor valid |
| d_ready | input | 1 | Descriptor accepted downstream |
| d_kind | output | 3 | Request kind (0..5, see R3-R5 codes) |
| d_addr | output | 32 | Target address |
| d_rid | output | 16 | Routing identifier |
| d_data | output | 32 | Write payload |
| d_be | output | 4 | Byte enables |
| d_len | output | 10 | Length in dwords |
| c_valid | input | 1 | Completion data valid |
| c_data | input | 32 | Completion data |

## Verification
The assertions assume a slave master that holds `s_valid` and the address stable until `s_ready`, and that raises `c_valid` only while a read is waiting for its data. The stall and gating checks also assume that bus-master-enable is not cleared while a descriptor is already being offered. The bench drives its inputs on falling edges. It drops `s_valid` in the response cycle, pulses `d_ready` and `c_valid` only when the block is waiting for them, and changes bus-master-enable and `link_up` only between accesses or while a request is stalled before issue.

// File: rtl/pcie_win_pkg.sv
// Shared widths, request kinds, descriptor layout and controller states
// for the outbound window translator. Assumes 32-bit addresses and data.
package pcie_win_pkg;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int RID_W  = 16;
    localparam int WIN_AW = 12;   // 4KB configuration and I/O windows
    localparam int LEN_W  = 10;
    localparam int BE_W   = DW / 8;

    typedef enum logic [2:0] {
        REQ_MEM_RD = 3'd0,
        REQ_MEM_WR = 3'd1,
        REQ_IO_RD  = 3'd2,
        REQ_IO_WR  = 3'd3,
        REQ_CFG_RD = 3'd4,
        REQ_CFG_WR = 3'd5
    } req_kind_e;

    typedef struct packed {
        req_kind_e        kind;
        logic [AW-1:0]    addr;
        logic [RID_W-1:0] rid;
        logic [DW-1:0]    data;
    } req_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } xl_state_e;
endpackage

// File: rtl/pcie_win_regs.sv
// Programming registers: I/O base (upper bits only), target routing
// identifier and bus-master-enable. Read data is combinational and the
// link status is shown read-only. Assumes one register access per cycle.
module pcie_win_regs
    import pcie_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             r_we,
    input  logic [1:0]       r_idx,
    input  logic [DW-1:0]    r_wdata,
    input  logic             link_up,
    output logic [DW-1:0]    r_rdata,
    output logic [AW-1:WIN_AW] io_base_hi,
    output logic [RID_W-1:0] tgt_rid,
    output logic             bme
);
    localparam logic [1:0] IDX_IOBASE = 2'd0;
    localparam logic [1:0] IDX_TARGET = 2'd1;
    localparam logic [1:0] IDX_CTRL   = 2'd2;

    // Register writes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_base_hi <= '0;
            tgt_rid    <= '0;
            bme        <= 1'b0;
        end else if (r_we) begin
            case (r_idx)
                IDX_IOBASE: io_base_hi <= r_wdata[AW-1:WIN_AW];
                IDX_TARGET: tgt_rid    <= r_wdata[RID_W-1:0];
                IDX_CTRL:   bme        <= r_wdata[0];
                default: ;
            endcase
        end
    end

    // Read-back multiplexer.
    always_comb begin
        r_rdata = '0;
        case (r_idx)
            IDX_IOBASE: r_rdata = {io_base_hi, {WIN_AW{1'b0}}};
            IDX_TARGET: r_rdata = {{(DW-RID_W){1'b0}}, tgt_rid};
            IDX_CTRL:   r_rdata = {{(DW-2){1'b0}}, link_up, bme};
            default:    r_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pcie_win_decode.sv
// Combinational window decoder: classifies a slave access, checks the
// single-beat and alignment rules and builds the outbound descriptor.
// Assumes that the windows do not overlap; if they did, configuration
// would win over I/O, and I/O over memory.
module pcie_win_decode
    import pcie_win_pkg::*;
#(
    parameter logic [AW-1:0] CFG_BASE = 32'h4000_0000,
    parameter logic [AW-1:0] IO_BASE  = 32'h4000_1000,
    parameter logic [AW-1:0] MEM_BASE = 32'h8000_0000,
    parameter int            MEM_AW   = 28
)(
    input  logic               s_write,
    input  logic               s_burst,
    input  logic [AW-1:0]      s_addr,
    input  logic [DW-1:0]      s_wdata,
    input  logic [AW-1:WIN_AW] io_base_hi,
    input  logic [RID_W-1:0]   tgt_rid,
    output logic               acc_ok,
    output logic               acc_needs_link,
    output req_desc_t          acc_desc
);
    logic cfg_hit, io_hit, mem_hit, aligned;

    // Window hit and legality tests.
    always_comb begin
        cfg_hit = (s_addr[AW-1:WIN_AW] == CFG_BASE[AW-1:WIN_AW]);
        io_hit  = (s_addr[AW-1:WIN_AW] == IO_BASE[AW-1:WIN_AW]);
        mem_hit = (s_addr[AW-1:MEM_AW] == MEM_BASE[AW-1:MEM_AW]);
        aligned = (s_addr[1:0] == 2'b00);
        acc_ok  = !s_burst && aligned && (cfg_hit || io_hit || mem_hit);
        acc_needs_link = cfg_hit || io_hit;
    end

    // Descriptor construction with base and identifier substitution.
    always_comb begin
        acc_desc      = '0;
        acc_desc.data = s_write ? s_wdata : '0;
        if (cfg_hit) begin
            acc_desc.kind = s_write ? REQ_CFG_WR : REQ_CFG_RD;
            acc_desc.addr = {{(AW-WIN_AW){1'b0}}, s_addr[WIN_AW-1:0]};
            acc_desc.rid  = tgt_rid;
        end else if (io_hit) begin
            acc_desc.kind = s_write ? REQ_IO_WR : REQ_IO_RD;
            acc_desc.addr = {io_base_hi, s_addr[WIN_AW-1:0]};
        end else begin
            acc_desc.kind = s_write ? REQ_MEM_WR : REQ_MEM_RD;
            acc_desc.addr = s_addr;
        end
    end
endmodule

// File: rtl/pcie_win_ctrl.sv
// Single-outstanding request controller. It accepts an access, offers
// the latched descriptor once issue is allowed, waits for completion
// data on reads and returns a one-cycle response. It assumes the slave
// master holds its request until s_ready.
module pcie_win_ctrl
    import pcie_win_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    input  logic          acc_ok,
    input  logic          acc_needs_link,
    input  req_desc_t     acc_desc,
    input  logic          bme,
    input  logic          link_up,
    input  logic          d_ready,
    input  logic          c_valid,
    input  logic [DW-1:0] c_data,
    output logic          d_valid,
    output req_desc_t     desc_q,
    output logic          s_ready,
    output logic          s_err,
    output logic [DW-1:0] s_rdata,
    output xl_state_e     state
);
    logic          need_link_q;
    logic          err_q;
    logic [DW-1:0] rdata_q;
    logic          issue_ok;
    logic          is_write;

    // Issue gate: bus mastering always, link only for cfg and I/O.
    always_comb begin
        issue_ok = bme && (!need_link_q || link_up);
        d_valid  = (state == ST_ISSUE) && issue_ok;
        is_write = desc_q.kind[0];
        s_ready  = (state == ST_RESP);
        s_err    = s_ready && err_q;
        s_rdata  = rdata_q;
    end

    // Request sequencing and response capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            desc_q      <= '0;
            need_link_q <= 1'b0;
            err_q       <= 1'b0;
            rdata_q     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (s_valid) begin
                        rdata_q <= '0;
                        if (acc_ok) begin
                            desc_q      <= acc_desc;
                            need_link_q <= acc_needs_link;
                            err_q       <= 1'b0;
                            state       <= ST_ISSUE;
                        end else begin
                            err_q <= 1'b1;
                            state <= ST_RESP;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (d_valid && d_ready)
                        state <= is_write ? ST_RESP : ST_WAIT;
                end
                ST_WAIT: begin
                    if (c_valid) begin
                        rdata_q <= c_data;
                        state   <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pcie_win_xlate.sv
// Top level of the outbound window translator: register file, window
// decoder and request controller. Descriptor byte enables and length
// are fixed, since only single-dword accesses get through.
module pcie_win_xlate
    import pcie_win_pkg::*;
#(
    parameter logic [31:0] CFG_BASE = 32'h4000_0000,
    parameter logic [31:0] IO_BASE  = 32'h4000_1000,
    parameter logic [31:0] MEM_BASE = 32'h8000_0000,
    parameter int          MEM_AW   = 28
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_valid,
    input  logic        s_write,
    input  logic        s_burst,
    input  logic [31:0] s_addr,
    input  logic [31:0] s_wdata,
    output logic        s_ready,
    output logic        s_err,
    output logic [31:0] s_rdata,
    input  logic        r_we,
    input  logic [1:0]  r_idx,
    input  logic [31:0] r_wdata,
    output logic [31:0] r_rdata,
    input  logic        link_up,
    output logic        d_valid,
    input  logic        d_ready,
    output logic [2:0]  d_kind,
    output logic [31:0] d_addr,
    output logic [15:0] d_rid,
    output logic [31:0] d_data,
    output logic [3:0]  d_be,
    output logic [9:0]  d_len,
    input  logic        c_valid,
    input  logic [31:0] c_data
);
    logic [AW-1:WIN_AW] io_base_hi;
    logic [RID_W-1:0]   tgt_rid;
    logic               bme;
    logic               acc_ok;
    logic               acc_needs_link;
    req_desc_t          acc_desc;
    req_desc_t          desc_q;
    xl_state_e          state;

    pcie_win_regs u_regs (
        .clk(clk), .rst_n(rst_n), .r_we(r_we), .r_idx(r_idx),
        .r_wdata(r_wdata), .link_up(link_up), .r_rdata(r_rdata),
        .io_base_hi(io_base_hi), .tgt_rid(tgt_rid), .bme(bme)
    );

    pcie_win_decode #(
        .CFG_BASE(CFG_BASE), .IO_BASE(IO_BASE),
        .MEM_BASE(MEM_BASE), .MEM_AW(MEM_AW)
    ) u_decode (
        .s_write(s_write), .s_burst(s_burst), .s_addr(s_addr),
        .s_wdata(s_wdata), .io_base_hi(io_base_hi), .tgt_rid(tgt_rid),
        .acc_ok(acc_ok), .acc_needs_link(acc_needs_link),
        .acc_desc(acc_desc)
    );

    pcie_win_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .acc_ok(acc_ok),
        .acc_needs_link(acc_needs_link), .acc_desc(acc_desc),
        .bme(bme), .link_up(link_up), .d_ready(d_ready),
        .c_valid(c_valid), .c_data(c_data), .d_valid(d_valid),
        .desc_q(desc_q), .s_ready(s_ready), .s_err(s_err),
        .s_rdata(s_rdata), .state(state)
    );

    // Descriptor field fan-out.
    always_comb begin
        d_kind = desc_q.kind;
        d_addr = desc_q.addr;
        d_rid  = desc_q.rid;
        d_data = desc_q.data;
        d_be   = {BE_W{1'b1}};
        d_len  = LEN_W'(1);
    end
endmodule

// File: rtl/pcie_win_sva.sv
// Property checker for the window translator, bound to the top level.
// It assumes a slave master that holds its request until s_ready.
module pcie_win_sva
    import pcie_win_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        s_valid,
    input logic        s_burst,
    input logic [31:0] s_addr,
    input logic        s_ready,
    input logic        s_err,
    input logic        d_valid,
    input logic        d_ready,
    input logic [2:0]  d_kind,
    input logic [31:0] d_addr,
    input logic [31:0] d_data,
    input logic [3:0]  d_be,
    input logic [9:0]  d_len,
    input logic        link_up,
    input logic        bme,
    input xl_state_e   state
);
    // Fixed byte enables and length on every offered descriptor.
    assert_be_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> (d_be == 4'hF) && (d_len == 10'd1));

    // No descriptor is offered while bus mastering is off.
    assert_bme_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> bme);

    // Configuration and I/O descriptors only with the link up.
    assert_link_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && (d_kind >= 3'd2)) |-> link_up);

    // Configuration addresses stay inside one 4KB function space.
    assert_cfg_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_kind[2]) |-> (d_addr[31:12] == 20'd0));

    // Bursts and misaligned accesses are refused in the next cycle.
    assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && s_valid && (s_burst || s_addr[1:0] != 2'b00))
        |=> (s_ready && s_err && !d_valid));

    // Responses last exactly one cycle.
    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    // A stalled descriptor keeps its fields.
    assert_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_ready) |=> ($stable(d_kind) && $stable(d_addr)
                                   && $stable(d_data)));
endmodule

bind pcie_win_xlate pcie_win_sva u_sva (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_burst(s_burst),
    .s_addr(s_addr), .s_ready(s_ready), .s_err(s_err),
    .d_valid(d_valid), .d_ready(d_ready), .d_kind(d_kind),
    .d_addr(d_addr), .d_data(d_data), .d_be(d_be), .d_len(d_len),
    .link_up(link_up), .bme(bme), .state(state)
);

// File: tb/pcie_win_xlate_tb.sv
module pcie_win_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 0, s_write = 0, s_burst = 0;
    logic [31:0] s_addr = 0, s_wdata = 0;
    logic        s_ready, s_err;
    logic [31:0] s_rdata;
    logic        r_we = 0;
    logic [1:0]  r_idx = 0;
    logic [31:0] r_wdata = 0, r_rdata;
    logic        link_up = 0;
    logic        d_valid, d_ready = 0;
    logic [2:0]  d_kind;
    logic [31:0] d_addr, d_data;
    logic [15:0] d_rid;
    logic [3:0]  d_be;
    logic [9:0]  d_len;
    logic        c_valid = 0;
    logic [31:0] c_data = 0;

    localparam logic [31:0] CFG_W = 32'h4000_0000;
    localparam logic [31:0] IO_W  = 32'h4000_1000;
    localparam logic [31:0] MEM_W = 32'h8000_0000;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] m_iobase = 0;
    logic [15:0] m_rid = 0;

    always #2 clk = ~clk;   // 250 MHz

    pcie_win_xlate u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] idx, input logic [31:0] v);
        @(negedge clk); r_we = 1; r_idx = idx; r_wdata = v;
        @(negedge clk); r_we = 0;
    endtask

    task automatic reg_check(input logic [1:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk); r_idx = idx; #1;
        chk(r_rdata === exp, tag, r_rdata, exp);
    endtask

    task automatic start(input bit w, input logic [31:0] a, input logic [31:0] d, input bit b);
        @(negedge clk);
        s_valid = 1; s_write = w; s_addr = a; s_wdata = d; s_burst = b;
    endtask

    // Expected descriptor kind and address for an in-window access.
    function automatic logic [2:0] exp_kind(input logic [31:0] a, input bit w);
        if (a[31:12] == CFG_W[31:12]) return w ? 3'd5 : 3'd4;
        if (a[31:12] == IO_W[31:12])  return w ? 3'd3 : 3'd2;
        return w ? 3'd1 : 3'd0;
    endfunction
    function automatic logic [31:0] exp_addr(input logic [31:0] a);
        if (a[31:12] == CFG_W[31:12]) return {20'd0, a[11:0]};
        if (a[31:12] == IO_W[31:12])  return {m_iobase[31:12], a[11:0]};
        return a;
    endfunction
    function automatic logic [15:0] exp_rid(input logic [31:0] a);
        return (a[31:12] == CFG_W[31:12]) ? m_rid : 16'd0;
    endfunction

    // Serve the descriptor and completion, then check the response.
    task automatic finish(input logic [31:0] rd, input string tag);
        int n = 0;
        logic [2:0] ek = exp_kind(s_addr, s_write);
        while (!d_valid && n < 64) begin
            chk(!s_ready, {tag, " no early response"}, 32'(s_ready), 0);
            @(negedge clk); n++;
        end
        chk(d_valid, {tag, " d_valid R10"}, 32'(d_valid), 1);
        chk(d_kind == ek, {tag, " kind R3 R4 R5"}, 32'(d_kind), 32'(ek));
        chk(d_addr == exp_addr(s_addr), {tag, " addr R3 R4 R5"}, d_addr, exp_addr(s_addr));
        chk(d_rid == exp_rid(s_addr), {tag, " rid R3 R5"}, 32'(d_rid), 32'(exp_rid(s_addr)));
        chk(d_be == 4'hF && d_len == 10'd1, {tag, " be/len R6"}, {d_be, 18'd0, d_len}, {4'hF, 18'd0, 10'd1});
        chk(d_data == (s_write ? s_wdata : 32'd0), {tag, " data R6"}, d_data, s_write ? s_wdata : 32'd0);
        d_ready = 1;
        @(negedge clk); d_ready = 0;
        if (!s_write) begin
            chk(!s_ready, {tag, " read waits R10"}, 32'(s_ready), 0);
            repeat (2) @(negedge clk);
            c_valid = 1; c_data = rd;
            @(negedge clk); c_valid = 0;
        end
        chk(s_ready && !s_err, {tag, " response R10"}, {s_ready, s_err}, 2'b10);
        if (!s_write) chk(s_rdata == rd, {tag, " rdata R10"}, s_rdata, rd);
        s_valid = 0; s_burst = 0;
        @(negedge clk);
        chk(!s_ready, {tag, " pulse R10"}, 32'(s_ready), 0);
    endtask

    task automatic finish_err(input string tag);
        @(negedge clk);
        chk(s_ready && s_err && !d_valid, {tag, " error R9"}, {d_valid, s_ready, s_err}, 3'b011);
        s_valid = 0; s_burst = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!s_ready && !d_valid, "reset outputs R1", {s_ready, d_valid}, 0);
        rst_n = 1;
        reg_check(0, 0, "reset iobase R1");
        reg_check(1, 0, "reset target R1");
        reg_check(2, 0, "reset ctrl R1");

        reg_write(0, 32'hABCD_E123); m_iobase = 32'hABCD_E000;
        reg_write(1, 32'hFFFF_3A5B); m_rid = 16'h3A5B;
        reg_check(0, 32'hABCD_E000, "iobase readback R2");
        reg_check(1, 32'h0000_3A5B, "target readback R2");
        link_up = 1;
        reg_check(2, 32'h2, "ctrl link bit R2");

        // R7: bus mastering off stalls silently, then issues.
        start(1, MEM_W + 32'h40, 32'h1111_2222, 0);
        repeat (8) begin
            @(negedge clk);
            chk(!d_valid && !s_ready, "bme stall R7", {d_valid, s_ready}, 0);
        end
        reg_write(2, 1);
        chk(d_valid, "bme release R7", 32'(d_valid), 1);
        finish(0, "bme write R7");
        reg_check(2, 32'h3, "ctrl readback R2");

        // R8: link down holds cfg and I/O, memory still goes.
        link_up = 0;
        start(0, CFG_W + 32'h10, 0, 0);
        repeat (8) begin
            @(negedge clk);
            chk(!d_valid && !s_ready, "link stall cfg R8", {d_valid, s_ready}, 0);
        end
        link_up = 1;
        finish(32'hCAFE_0001, "cfg read R3");
        link_up = 0;
        start(1, IO_W + 32'hFFC, 32'h5555_AAAA, 0);
        repeat (6) begin
            @(negedge clk);
            chk(!d_valid && !s_ready, "link stall io R8", {d_valid, s_ready}, 0);
        end
        link_up = 1;
        finish(0, "io write R4");
        link_up = 0;
        start(0, MEM_W + 32'h0FFF_FFFC, 0, 0);
        finish(32'h0BAD_F00D, "mem read link down R8");
        link_up = 1;

        // R9 corner cases.
        start(0, MEM_W, 0, 1);           finish_err("burst R9");
        start(1, IO_W + 32'h2, 32'h1, 0); finish_err("misaligned R9");
        start(0, 32'h4000_2000, 0, 0);   finish_err("outside R9");
        start(1, 32'h0000_1000, 0, 0);   finish_err("outside low R9");

        // Boundaries of each window.
        start(1, CFG_W + 32'hFFC, 32'h0F0F_0F0F, 0); finish(0, "cfg write top R3");
        start(0, IO_W, 0, 0);                       finish(32'h1234_5678, "io read base R4");
        start(1, MEM_W, 32'hDEAD_BEEF, 0);          finish(0, "mem write base R5");

        // Constrained random mix.
        for (int i = 0; i < 80; i++) begin
            int sel = $urandom % 8;
            bit w = $urandom % 2;
            logic [31:0] off = $urandom;
            logic [31:0] a;
            if (i % 20 == 0) begin
                reg_write(1, $urandom); m_rid = r_wdata[15:0];
                reg_write(0, $urandom); m_iobase = {r_wdata[31:12], 12'd0};
            end
            case (sel)
                0, 1: a = CFG_W + {20'd0, off[11:2], 2'b00};
                2, 3: a = IO_W + {20'd0, off[11:2], 2'b00};
                4, 5, 6: a = MEM_W + {4'd0, off[27:2], 2'b00};
                default: a = {off[31:2], 2'b01};
            endcase
            start(w, a, $urandom, 0);
            if (sel == 7) finish_err("random reject R9");
            else finish($urandom, "random access R11");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule